// File: doc/BRIEF.md
# Free-Rectangle Placement Selector

This block picks a landing spot for a rectangular hardware module on a reconfigurable fabric. A host keeps a small table of empty rectangles, each with a bottom-left corner (x, y), a width and a height, and writes it through a plain write port. A placement request gives the module's width and height and a packing policy. The block then walks the table, one entry per clock cycle. It returns the index of the chosen rectangle and the position where the module lands, or it reports that no rectangle can hold the module.

Three packing policies can be selected with each request. First fit takes the earliest suitable entry. Best fit takes the entry that wastes the least area. Bottom left takes the entry whose corner is lowest, and then leftmost. The host still has to update the table after a placement and compute maximal empty rectangles itself.

Requests enter on a valid/ready handshake. One request is in flight at a time, and `req_ready` stays low from acceptance until the response has been taken. The response is held on a valid/ready handshake. While `rsp_ready` is low the response stays put and no new request is accepted, so back-pressure on the result stalls the block's input.

Top module: `rect_place_sel`

## Requirements
- R1: An entry is eligible only when its valid bit is set, its width is at least the requested width and its height is at least the requested height, with equality allowed. When no entry is eligible, the response has `rsp_found`=0 and `rsp_idx`, `rsp_x` and `rsp_y` all zero.
- R2: Under policy code 0 (first fit) the eligible entry with the lowest table index is chosen. Policy code 3 behaves as code 0.
- R3: Under policy code 1 (best fit) the chosen entry has the smallest waste, where waste is width*height of the entry minus width*height of the module. Equal waste goes to the lowest index.
- R4: Under policy code 2 (bottom left) the chosen entry has the smallest y. Equal y is broken by the smallest x, and any remaining tie goes to the lowest index.
- R5: On success the response carries `rsp_found`=1, the chosen index, and the bottom-left corner of the chosen entry as the module position.
- R6: A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. `rsp_valid` goes high exactly NUM_ENTRIES clock cycles after the accepting edge, and `req_ready` stays low from the accepting edge until the response has been taken.
- R7: While `rsp_valid` is high and `rsp_ready` is low, all response fields hold stable. On an edge where both are high the response is consumed: `rsp_valid` falls and `req_ready` returns high after that edge.
- R8: A table write takes effect at the clock edge where `cfg_we` is high. Writing `cfg_valid`=0 removes an entry. Reset clears every valid bit, so any request made right after reset is rejected.
- R9: The request width, height and policy are captured at acceptance. Changes on those inputs during the scan have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write enable |
| cfg_idx | input | IDX_W | Table entry to write |
| cfg_valid | input | 1 | Valid bit written to the entry |
| cfg_x | input | COORD_W | Bottom-left x of the empty rectangle |
| cfg_y | input | COORD_W | Bottom-left y of the empty rectangle |
| cfg_w | input | COORD_W | Width of the empty rectangle |
| cfg_h | input | COORD_W | Height of the empty rectangle |
| req_valid | input | 1 | Placement request valid |
| req_ready | output | 1 | Block can accept a request |
| req_w | input | COORD_W | Module width |
| req_h | input | COORD_W | Module height |
| req_policy | input | 2 | 0 first fit, 1 best fit, 2 bottom left, 3 as 0 |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_found | output | 1 | A rectangle was chosen |
| rsp_idx | output | IDX_W | Index of the chosen rectangle |
| rsp_x | output | COORD_W | Module placement x |
| rsp_y | output | COORD_W | Module placement y |

## Verification
The bench builds a table in which first fit, best fit and bottom left each choose a different entry. A design that confused the policies, or mixed up their tie rules, would return the wrong index. The table also includes a higher-indexed entry whose waste equals the best fit winner, two entries that share a y with different x, and two entries that share a corner exactly. Any of these exposes a comparison that is not strict or a tie broken in favour of the later entry. Other cases test fits with equality on both dimensions, an invalid entry large enough to win if its valid bit were ignored, an entry that fails on only one dimension, a module too large for every entry, and the reserved policy code. The bench also stalls the response, changes the request inputs during the scan, and removes an entry. These catch results that drift under back-pressure, requests that are re-sampled after acceptance, and deletions that are not honoured.

// File: rtl/rps_pkg.sv
package rps_pkg;
  typedef enum logic [1:0] {
    POL_FIRST = 2'd0,
    POL_BEST  = 2'd1,
    POL_BLEFT = 2'd2,
    POL_ALT   = 2'd3
  } policy_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } scan_state_e;
endpackage

// File: rtl/rps_table.sv
module rps_table #(
  parameter int NUM_ENTRIES = 16,
  parameter int COORD_W     = 8,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_valid,
  input  logic [COORD_W-1:0] wr_x,
  input  logic [COORD_W-1:0] wr_y,
  input  logic [COORD_W-1:0] wr_w,
  input  logic [COORD_W-1:0] wr_h,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_valid,
  output logic [COORD_W-1:0] rd_x,
  output logic [COORD_W-1:0] rd_y,
  output logic [COORD_W-1:0] rd_w,
  output logic [COORD_W-1:0] rd_h
);
  logic               ent_v [NUM_ENTRIES];
  logic [COORD_W-1:0] ent_x [NUM_ENTRIES];
  logic [COORD_W-1:0] ent_y [NUM_ENTRIES];
  logic [COORD_W-1:0] ent_w [NUM_ENTRIES];
  logic [COORD_W-1:0] ent_h [NUM_ENTRIES];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_v[g] <= 1'b0;
      end else if (hit) begin
        ent_v[g] <= wr_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_x[g] <= '0;
        ent_y[g] <= '0;
        ent_w[g] <= '0;
        ent_h[g] <= '0;
      end else if (hit) begin
        ent_x[g] <= wr_x;
        ent_y[g] <= wr_y;
        ent_w[g] <= wr_w;
        ent_h[g] <= wr_h;
      end
    end
  end

  assign rd_valid = ent_v[rd_idx];
  assign rd_x     = ent_x[rd_idx];
  assign rd_y     = ent_y[rd_idx];
  assign rd_w     = ent_w[rd_idx];
  assign rd_h     = ent_h[rd_idx];
endmodule

// File: rtl/rps_fit_eval.sv
module rps_fit_eval
  import rps_pkg::*;
#(
  parameter int COORD_W = 8,
  parameter int AREA_W  = 2 * COORD_W
) (
  input  logic               cand_valid,
  input  logic [COORD_W-1:0] cand_x,
  input  logic [COORD_W-1:0] cand_y,
  input  logic [COORD_W-1:0] cand_w,
  input  logic [COORD_W-1:0] cand_h,
  input  logic [COORD_W-1:0] mod_w,
  input  logic [COORD_W-1:0] mod_h,
  input  policy_e            policy,
  input  logic               have_best,
  input  logic [COORD_W-1:0] best_x,
  input  logic [COORD_W-1:0] best_y,
  input  logic [AREA_W-1:0]  best_waste,
  output logic               fits,
  output logic               better,
  output logic [AREA_W-1:0]  cand_waste
);
  logic [AREA_W-1:0] cand_area;
  logic [AREA_W-1:0] mod_area;
  logic              lower_corner;

  always_comb begin
    cand_area  = AREA_W'(cand_w) * AREA_W'(cand_h);
    mod_area   = AREA_W'(mod_w) * AREA_W'(mod_h);
    cand_waste = cand_area - mod_area;
    fits       = cand_valid && (cand_w >= mod_w) && (cand_h >= mod_h);
    lower_corner = (cand_y < best_y) || ((cand_y == best_y) && (cand_x < best_x));
  end

  always_comb begin
    better = 1'b0;
    if (fits) begin
      if (!have_best) begin
        better = 1'b1;
      end else begin
        unique case (policy)
          POL_BEST:  better = cand_waste < best_waste;
          POL_BLEFT: better = lower_corner;
          default:   better = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/rps_scan_ctrl.sv
module rps_scan_ctrl
  import rps_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int COORD_W     = 8,
  parameter int IDX_W       = $clog2(NUM_ENTRIES),
  parameter int AREA_W      = 2 * COORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [COORD_W-1:0] req_w,
  input  logic [COORD_W-1:0] req_h,
  input  logic [1:0]         req_policy,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_found,
  output logic [IDX_W-1:0]   rsp_idx,
  output logic [COORD_W-1:0] rsp_x,
  output logic [COORD_W-1:0] rsp_y,
  output logic [IDX_W-1:0]   scan_idx,
  output logic [COORD_W-1:0] mod_w,
  output logic [COORD_W-1:0] mod_h,
  output policy_e            policy,
  output logic               have_best,
  output logic [COORD_W-1:0] best_x,
  output logic [COORD_W-1:0] best_y,
  output logic [AREA_W-1:0]  best_waste,
  input  logic               cand_better,
  input  logic [COORD_W-1:0] cand_x,
  input  logic [COORD_W-1:0] cand_y,
  input  logic [AREA_W-1:0]  cand_waste
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  scan_state_e      state;
  logic [IDX_W-1:0] best_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      scan_idx   <= '0;
      mod_w      <= '0;
      mod_h      <= '0;
      policy     <= POL_FIRST;
      have_best  <= 1'b0;
      best_idx   <= '0;
      best_x     <= '0;
      best_y     <= '0;
      best_waste <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            mod_w      <= req_w;
            mod_h      <= req_h;
            policy     <= policy_e'(req_policy);
            scan_idx   <= '0;
            have_best  <= 1'b0;
            best_idx   <= '0;
            best_x     <= '0;
            best_y     <= '0;
            best_waste <= '0;
            state      <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (cand_better) begin
            have_best  <= 1'b1;
            best_idx   <= scan_idx;
            best_x     <= cand_x;
            best_y     <= cand_y;
            best_waste <= cand_waste;
          end
          if (scan_idx == LAST_IDX) begin
            state <= ST_DONE;
          end else begin
            scan_idx <= scan_idx + 1'b1;
          end
        end
        ST_DONE: begin
          if (rsp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_DONE);
  assign rsp_found = have_best;
  assign rsp_idx   = best_idx;
  assign rsp_x     = best_x;
  assign rsp_y     = best_y;
endmodule

// File: rtl/rect_place_sel.sv
module rect_place_sel
  import rps_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int COORD_W     = 8,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic               cfg_valid,
  input  logic [COORD_W-1:0] cfg_x,
  input  logic [COORD_W-1:0] cfg_y,
  input  logic [COORD_W-1:0] cfg_w,
  input  logic [COORD_W-1:0] cfg_h,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [COORD_W-1:0] req_w,
  input  logic [COORD_W-1:0] req_h,
  input  logic [1:0]         req_policy,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_found,
  output logic [IDX_W-1:0]   rsp_idx,
  output logic [COORD_W-1:0] rsp_x,
  output logic [COORD_W-1:0] rsp_y
);
  localparam int AREA_W = 2 * COORD_W;

  logic [IDX_W-1:0]   scan_idx;
  logic               cand_valid;
  logic [COORD_W-1:0] cand_x, cand_y, cand_w, cand_h;
  logic [COORD_W-1:0] mod_w, mod_h;
  policy_e            policy;
  logic               have_best;
  logic [COORD_W-1:0] best_x, best_y;
  logic [AREA_W-1:0]  best_waste, cand_waste;
  logic               cand_fits, cand_better;

  rps_table #(.NUM_ENTRIES(NUM_ENTRIES), .COORD_W(COORD_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_valid(cfg_valid),
    .wr_x(cfg_x), .wr_y(cfg_y), .wr_w(cfg_w), .wr_h(cfg_h),
    .rd_idx(scan_idx), .rd_valid(cand_valid),
    .rd_x(cand_x), .rd_y(cand_y), .rd_w(cand_w), .rd_h(cand_h)
  );

  rps_fit_eval #(.COORD_W(COORD_W), .AREA_W(AREA_W)) u_eval (
    .cand_valid(cand_valid), .cand_x(cand_x), .cand_y(cand_y),
    .cand_w(cand_w), .cand_h(cand_h),
    .mod_w(mod_w), .mod_h(mod_h), .policy(policy),
    .have_best(have_best), .best_x(best_x), .best_y(best_y), .best_waste(best_waste),
    .fits(cand_fits), .better(cand_better), .cand_waste(cand_waste)
  );

  rps_scan_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .COORD_W(COORD_W), .IDX_W(IDX_W), .AREA_W(AREA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_w(req_w), .req_h(req_h), .req_policy(req_policy),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_found(rsp_found),
    .rsp_idx(rsp_idx), .rsp_x(rsp_x), .rsp_y(rsp_y),
    .scan_idx(scan_idx), .mod_w(mod_w), .mod_h(mod_h), .policy(policy),
    .have_best(have_best), .best_x(best_x), .best_y(best_y), .best_waste(best_waste),
    .cand_better(cand_better), .cand_x(cand_x), .cand_y(cand_y), .cand_waste(cand_waste)
  );
endmodule

// File: rtl/rps_checker.sv
module rps_checker #(
  parameter int NUM_ENTRIES = 16,
  parameter int COORD_W     = 8,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic               rsp_found,
  input logic [IDX_W-1:0]   rsp_idx,
  input logic [COORD_W-1:0] rsp_x,
  input logic [COORD_W-1:0] rsp_y,
  input logic               cand_fits,
  input logic               cand_better
);
  localparam int CYC_W = $clog2(NUM_ENTRIES + 2) + 1;

  logic [CYC_W-1:0] cyc;
  logic             busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc  <= '0;
      busy <= 1'b0;
    end else if (req_valid && req_ready) begin
      cyc  <= '0;
      busy <= 1'b1;
    end else if (busy && !rsp_valid) begin
      cyc <= cyc + 1'b1;
    end else if (rsp_valid && rsp_ready) begin
      busy <= 1'b0;
    end
  end

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> (cyc == CYC_W'(NUM_ENTRIES))) else $error("latency"); // R6

  AST_NO_READY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready) else $error("ready after accept"); // R6

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_found) && $stable(rsp_idx)
                                   && $stable(rsp_x) && $stable(rsp_y))) else $error("hold"); // R7

  AST_RSP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> (!rsp_valid && req_ready)) else $error("release"); // R7

  AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_found) |-> (rsp_idx == '0 && rsp_x == '0 && rsp_y == '0)) else $error("reject"); // R1

  AST_BETTER_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    cand_better |-> cand_fits) else $error("unfit pick"); // R1
endmodule

bind rect_place_sel rps_checker #(.NUM_ENTRIES(NUM_ENTRIES), .COORD_W(COORD_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_found(rsp_found),
  .rsp_idx(rsp_idx), .rsp_x(rsp_x), .rsp_y(rsp_y),
  .cand_fits(cand_fits), .cand_better(cand_better)
);

// File: tb/rect_place_sel_tb.sv
module rect_place_sel_tb;
  localparam int N  = 16;
  localparam int CW = 8;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic          cfg_valid = 1'b0;
  logic [CW-1:0] cfg_x = '0, cfg_y = '0, cfg_w = '0, cfg_h = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [CW-1:0] req_w = '0, req_h = '0;
  logic [1:0]    req_policy = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic          rsp_found;
  logic [IW-1:0] rsp_idx;
  logic [CW-1:0] rsp_x, rsp_y;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rect_place_sel #(.NUM_ENTRIES(N), .COORD_W(CW), .IDX_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
    .cfg_x(cfg_x), .cfg_y(cfg_y), .cfg_w(cfg_w), .cfg_h(cfg_h),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_w(req_w), .req_h(req_h), .req_policy(req_policy),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_found(rsp_found),
    .rsp_idx(rsp_idx), .rsp_x(rsp_x), .rsp_y(rsp_y)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_entry(input int idx, input bit v, input int x, input int y,
                             input int w, input int h);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_valid = v;
    cfg_x = CW'(x); cfg_y = CW'(y); cfg_w = CW'(w); cfg_h = CW'(h);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // One request end to end; request inputs are scrambled during the scan (R9)
  task automatic place(input string req, input int mw, input int mh, input int pol,
                       input int stall, input bit ef, input int ei, input int ex, input int ey);
    int n;
    @(negedge clk);
    chk("R6", "req_ready idle", int'(req_ready), 1);
    req_w = CW'(mw); req_h = CW'(mh); req_policy = 2'(pol); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_w = ~CW'(mw); req_h = ~CW'(mh); req_policy = 2'(pol) ^ 2'd1;
    chk("R6", "req_ready busy", int'(req_ready), 0);
    n = 0;
    while (!rsp_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R6", "latency", n, N);
    chk(req, "found", int'(rsp_found), int'(ef));
    chk(req, "idx", int'(rsp_idx), ei);
    chk(req, "x", int'(rsp_x), ex);
    chk(req, "y", int'(rsp_y), ey);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk("R7", "held valid", int'(rsp_valid), 1);
      chk("R7", "held idx", int'(rsp_idx), ei);
      chk("R7", "held x", int'(rsp_x), ex);
      chk("R7", "req_ready stalled", int'(req_ready), 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R7", "valid after take", int'(rsp_valid), 0);
    chk("R7", "ready after take", int'(req_ready), 1);
  endtask

  task automatic t_reset;
    chk("R8", "reset req_ready", int'(req_ready), 1);
    chk("R8", "reset rsp_valid", int'(rsp_valid), 0);
    place("R8", 1, 1, 0, 0, 1'b0, 0, 0, 0);
  endtask

  task automatic t_load;
    write_entry(0, 1'b0, 0, 0, 200, 200);   // large but invalid (R1)
    write_entry(1, 1'b1, 5, 5, 8, 50);
    write_entry(2, 1'b1, 100, 60, 40, 40);
    write_entry(3, 1'b1, 30, 20, 20, 15);
    write_entry(4, 1'b1, 70, 10, 50, 50);
    write_entry(5, 1'b1, 10, 10, 12, 30);
    write_entry(6, 1'b1, 150, 150, 10, 20);
    write_entry(7, 1'b1, 0, 0, 9, 9);
    write_entry(8, 1'b1, 0, 220, 10, 20);
    write_entry(9, 1'b1, 10, 10, 30, 30);
  endtask

  task automatic t_first_fit;
    place("R2", 10, 10, 0, 0, 1'b1, 2, 100, 60);
    place("R2", 3, 3, 3, 0, 1'b1, 1, 5, 5);      // code 3 acts as first fit
    place("R1", 8, 50, 0, 0, 1'b1, 1, 5, 5);     // exact fit on both sides
    place("R5", 45, 45, 0, 0, 1'b1, 4, 70, 10);
  endtask

  task automatic t_best_fit;
    place("R3", 10, 10, 1, 0, 1'b1, 6, 150, 150); // waste tie with idx 8
    place("R3", 10, 20, 1, 3, 1'b1, 6, 150, 150); // zero waste, stalled
  endtask

  task automatic t_bottom_left;
    place("R4", 10, 10, 2, 0, 1'b1, 5, 10, 10);   // y tie 4/5/9, x tie 5/9
    place("R4", 30, 30, 2, 0, 1'b1, 9, 10, 10);
  endtask

  task automatic t_reject;
    place("R1", 255, 255, 1, 2, 1'b0, 0, 0, 0);
  endtask

  task automatic t_remove;
    write_entry(6, 1'b0, 150, 150, 10, 20);
    place("R8", 10, 10, 1, 0, 1'b1, 8, 0, 220);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_first_fit();
    t_best_fit();
    t_bottom_left();
    t_reject();
    t_remove();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule